// File: doc/BRIEF.md
# Delayed Feedback Bus Driver with Guard Override

This block takes a pixel data bus and hands out a copy of it, delayed by a fixed number of system clocks, for driving a memory data bus that other devices also share. The copy runs through a register pipeline that keeps clocking at all times. Whether the copy is actually driven onto the shared bus is set by a single mode bit, which the control interface writes through a write strobe.

A separate guard input is asynchronous to the clock and is used during power-up or other unsafe periods. While it is high, the output enable drops at once, straight from the pin, and the programmed mode is overruled. When the guard falls, the enable comes back under the control of the stored mode bit. The release passes through a two-flop synchronizer first, so the bus is only driven again on a clean clock boundary. The stored mode survives the guard pulse, so nothing needs to be written again.

The delayed data and the enable are available as separate outputs. The block also drives them onto a bidirectional port through a tri-state buffer.

Top module: `fb_tap_bus`

## Requirements
- R1: `dout` equals the value `din` held four rising clock edges earlier, counting only edges after reset.
- R2: While `rst` is high and after it falls, `dout` is zero until new data arrives through the pipeline, and `oe` is low because the mode bit resets to the high-impedance setting (0).
- R3: A write (`mode_we` high at a rising edge) stores `mode_val`. With the guard settled low, `oe` equals the stored value from the next edge on: 1 means drive, 0 means high impedance.
- R4: Whenever `guard_i` is high, `oe` is low at once, without waiting for a clock edge, for either stored mode.
- R5: After `guard_i` falls, `oe` stays low through the first rising edge and follows the stored mode from the second rising edge on.
- R6: The delay pipeline keeps shifting while `oe` is low, so `dout` keeps the four-cycle relation across a guard pulse.
- R7: The stored mode is kept through a guard pulse, so `oe` returns to its earlier value without a new write.
- R8: A mode write made while `guard_i` is high is stored, and it takes effect only once the guard release has been synchronized.
- R9: While `oe` is high, `bus` carries `dout`. While `oe` is low, `bus` is released to high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, line-locked to video |
| rst | input | 1 | Synchronous active-high reset |
| guard_i | input | 1 | Asynchronous guard; forces high impedance while high |
| mode_we | input | 1 | Write strobe for the drive mode bit |
| mode_val | input | 1 | Mode value: 1 drive, 0 high impedance |
| din | input | DATA_W | Field-1 pixel data in |
| dout | output | DATA_W | Delayed copy of `din` |
| oe | output | 1 | Output enable for the shared bus |
| bus | inout | DATA_W | Tri-state copy of `dout` |

## Verification
A wrong pipeline stage shows up on `dout` four edges after the bad value enters, as a wrong or shifted pixel value. It does not matter whether the bus is enabled at the time. A mode register or synchronizer that holds the wrong value shows up on `oe`. A lost write is visible one edge after the write. A release that is too early or too late is visible on the first or second edge after the guard falls. A missing combinational override is visible within a fraction of a cycle after the guard rises, before any clock edge.

// File: rtl/fb_tap_pkg.sv
package fb_tap_pkg;

    localparam int unsigned FB_TAP_LAT  = 4;
    localparam int unsigned FB_TAP_SYNC = 2;

    typedef enum logic {
        FB_HIZ   = 1'b0,
        FB_DRIVE = 1'b1
    } fb_drive_e;

    typedef struct packed {
        fb_drive_e mode;
        logic      guard_raw;
        logic      guard_held;
    } fb_en_t;

    // Drive only when programmed to and neither guard view is active.
    function automatic logic fb_enable(input fb_en_t s);
        return (s.mode == FB_DRIVE) && !s.guard_raw && !s.guard_held;
    endfunction

endpackage

// File: rtl/fb_tap_delay.sv
module fb_tap_delay #(
    parameter int unsigned W   = 8,
    parameter int unsigned LAT = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar k = 0; k < LAT; k++) begin : g_stage
        logic [W-1:0] q;
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= g_stage[k-1].q;
            end
        end
    end

    assign dout = g_stage[LAT-1].q;

endmodule

// File: rtl/fb_tap_enable.sv
module fb_tap_enable
    import fb_tap_pkg::*;
#(
    parameter int unsigned SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic guard_i,
    input  logic mode_we,
    input  logic mode_val,
    output logic oe
);

    fb_drive_e         mode_q;
    logic [SYNC-1:0]   sync_q;
    fb_en_t            en_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= FB_HIZ;
        end else if (mode_we) begin
            mode_q <= fb_drive_e'(mode_val);
        end
    end

    // Synchronizer starts in the guarded state so reset release is clean.
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC-2:0], guard_i};
    end

    always_comb begin
        en_s.mode       = mode_q;
        en_s.guard_raw  = guard_i;
        en_s.guard_held = sync_q[SYNC-1];
        oe              = fb_enable(en_s);
    end

endmodule

// File: rtl/fb_tap_bus.sv
module fb_tap_bus
    import fb_tap_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LAT    = FB_TAP_LAT,
    parameter int unsigned SYNC   = FB_TAP_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              guard_i,
    input  logic              mode_we,
    input  logic              mode_val,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              oe,
    inout  wire  [DATA_W-1:0] bus
);

    fb_tap_delay #(.W(DATA_W), .LAT(LAT)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .dout (dout)
    );

    fb_tap_enable #(.SYNC(SYNC)) u_enable (
        .clk      (clk),
        .rst      (rst),
        .guard_i  (guard_i),
        .mode_we  (mode_we),
        .mode_val (mode_val),
        .oe       (oe)
    );

    assign bus = oe ? dout : {DATA_W{1'bz}};

endmodule

// File: rtl/fb_tap_chk.sv
module fb_tap_chk #(
    parameter int unsigned W   = 8,
    parameter int unsigned LAT = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         guard_i,
    input logic         mode_we,
    input logic         mode_val,
    input logic [W-1:0] din,
    input logic [W-1:0] dout,
    input logic         oe
);

    localparam int unsigned CNT_MAX = LAT + 4;

    int unsigned  cnt;
    logic [W-1:0] ref_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= 0;
        end else if (cnt < CNT_MAX) begin
            cnt <= cnt + 1;
        end
        ref_q[0] <= din;
        for (int k = 1; k < LAT; k++) ref_q[k] <= ref_q[k-1];
    end

    // R1 / R6: fixed latency, also during a guard pulse
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt >= LAT) |-> (dout == ref_q[LAT-1]));

    // R4: guard forces the enable low
    p_guard_off_r4: assert property (@(posedge clk) disable iff (rst)
        guard_i |-> !oe);

    // R5: still off one edge after the guard falls
    p_release_late_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(guard_i) |=> !oe);

    // R5: a rising enable needs three low guard samples
    p_rise_clean_r5: assert property (@(posedge clk) disable iff (rst)
        ((cnt >= 2) && $rose(oe)) |-> (!guard_i && !$past(guard_i) && !$past(guard_i, 2)));

    // R3: a written mode shows one edge later when the guard is settled
    p_mode_write_r3: assert property (@(posedge clk) disable iff (rst)
        ((cnt >= 3) && !guard_i && !$past(guard_i) && !$past(guard_i, 2) && $past(mode_we))
        |-> (oe == $past(mode_val)));

endmodule

bind fb_tap_bus fb_tap_chk #(.W(DATA_W), .LAT(LAT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .guard_i  (guard_i),
    .mode_we  (mode_we),
    .mode_val (mode_val),
    .din      (din),
    .dout     (dout),
    .oe       (oe)
);

// File: tb/test_fb_tap_bus.sv
module test_fb_tap_bus;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int W = 8;

    logic         clk      = 1'b0;
    logic         rst      = 1'b1;
    logic         guard_i  = 1'b0;
    logic         mode_we  = 1'b0;
    logic         mode_val = 1'b0;
    logic [W-1:0] din      = '0;
    wire  [W-1:0] dout;
    wire          oe;
    wire  [W-1:0] bus;

    always #2.5 clk = ~clk;

    fb_tap_bus #(.DATA_W(W)) i_fb_tap_bus (
        .clk      (clk),
        .rst      (rst),
        .guard_i  (guard_i),
        .mode_we  (mode_we),
        .mode_val (mode_val),
        .din      (din),
        .dout     (dout),
        .oe       (oe),
        .bus      (bus)
    );

    int           n_chk = 0;
    int           n_bad = 0;
    int           n_in  = 0;
    logic [W-1:0] hist [256];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: at the falling edge compare dout against the value driven
    // four cycles back, then drive the next data word and optional write.
    task automatic cyc(input logic [W-1:0] v, input string req,
                       input bit we = 1'b0, input bit val = 1'b0);
        @(negedge clk);
        if (n_in >= 4)
            check(dout == hist[(n_in - 4) % 256], req, int'(dout), int'(hist[(n_in - 4) % 256]));
        din      = v;
        mode_we  = we;
        mode_val = val;
        hist[n_in % 256] = v;
        n_in++;
    endtask

    task automatic set_mode(input bit val);
        cyc(8'h11, "R1", 1'b1, val);
        cyc(8'h22, "R1");
        check(oe == val, "R3", int'(oe), int'(val));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(dout == '0, "R2", int'(dout), 0);
        check(oe == 1'b0, "R2", int'(oe), 0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cyc(8'(i + 1), "R1");
            check(oe == 1'b0, "R2", int'(oe), 0);
        end
        check(dout == '0, "R2", int'(dout), 0);
    endtask

    task automatic t_latency;
        for (int i = 0; i < 16; i++) cyc(8'(i * 17 + 3), "R1");
        cyc(8'hFF, "R1");
        cyc(8'h00, "R1");
        cyc(8'hAA, "R1");
        cyc(8'h55, "R1");
    endtask

    task automatic t_mode;
        set_mode(1'b1);
        cyc(8'h3C, "R1");
        check(bus == dout, "R9", int'(bus), int'(dout));
        cyc(8'hC3, "R1");
        check(oe == 1'b1, "R3", int'(oe), 1);
        set_mode(1'b0);
        cyc(8'h77, "R1");
        check(oe == 1'b0, "R3", int'(oe), 0);
    endtask

    task automatic t_guard(input bit m);
        set_mode(m);
        cyc(8'h40, "R1");
        #0.5 guard_i = 1'b1;
        #0.5 check(oe == 1'b0, "R4", int'(oe), 0);
        for (int i = 0; i < 6; i++) begin
            cyc(8'(8'h80 + i * 5), "R6");
            check(oe == 1'b0, "R4", int'(oe), 0);
        end
        cyc(8'h9A, "R6");
        #0.5 guard_i = 1'b0;
        #0.5 check(oe == 1'b0, "R5", int'(oe), 0);
        cyc(8'h9B, "R6");
        check(oe == 1'b0, "R5", int'(oe), 0);
        cyc(8'h9C, "R6");
        check(oe == m, "R7", int'(oe), int'(m));
        cyc(8'h9D, "R6");
        check(oe == m, "R5", int'(oe), int'(m));
    endtask

    task automatic t_write_in_guard;
        set_mode(1'b0);
        cyc(8'h61, "R1");
        #0.5 guard_i = 1'b1;
        cyc(8'h62, "R6", 1'b1, 1'b1);
        cyc(8'h63, "R6");
        check(oe == 1'b0, "R8", int'(oe), 0);
        cyc(8'h64, "R6");
        #0.5 guard_i = 1'b0;
        cyc(8'h65, "R6");
        check(oe == 1'b0, "R8", int'(oe), 0);
        cyc(8'h66, "R6");
        check(oe == 1'b1, "R8", int'(oe), 1);
        check(bus == dout, "R9", int'(bus), int'(dout));
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_latency();
        t_mode();
        t_guard(1'b1);
        t_guard(1'b0);
        t_write_in_guard();
        for (int i = 0; i < 6; i++) cyc(8'(i), "R1");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule